// File: doc/BRIEF.md
# Interrupt Cause Hub

The block gathers interrupt causes into one 32-bit status word and turns them into a request toward the host. Software sets causes by writing a bit mask to a raise address and removes them by writing a bit mask to a lower address; it reads the status word back at its own address. Internal engines (a factorial unit and a DMA engine in the default setup) raise their causes through single-cycle pulse inputs, each mapped by parameter to a fixed status bit.

Delivery follows the `msi_en` input. With it low, the block drives a level interrupt line that is high exactly while at least one cause is pending. With it high, the level line stays low and every raise operation that leaves a pending cause produces a one-cycle message request pulse; removing causes never sends a message. Message formatting and configuration space live outside the block.

Top module: `irq_cause_hub`

## Requirements
- R1: During and after reset, until the first operation, the status reads zero, `irq_level` is 0 and `msi_req` is 0.
- R2: A write to the raise address (offset 0x60) ORs `wr_data` into the status; the new value reads back in the next cycle.
- R3: A write to the lower address (offset 0x64) clears exactly the status bits that are 1 in `wr_data` and leaves the others unchanged.
- R4: With `rd_addr` equal to the status offset 0x24, `rd_data` shows the status combinationally; any other read offset returns zero.
- R5: A pulse on `src_raise[0]` sets status bit 0 (factorial done, 0x00000001) and a pulse on `src_raise[1]` sets status bit 8 (DMA done, 0x00000100).
- R6: When a lower write and a raise (engine pulse or raise write) fall in the same cycle, the lower is applied first and the raise second, so the raised bits end up set.
- R7: With `msi_en` low, a raise that leaves the status nonzero drives `irq_level` high in the next cycle.
- R8: With `msi_en` low, `irq_level` stays high after a lower that leaves some cause pending and falls only when the status becomes zero.
- R9: With `msi_en` high, each raise operation (including a raise write of zero) that leaves the status nonzero gives exactly one `msi_req` pulse in the next cycle; a lower write, or a raise leaving the status zero, gives none.
- R10: While `msi_en` is high, `irq_level` is held low; one cycle after `msi_en` returns low, `irq_level` again equals whether the status is nonzero.
- R11: Writes to any offset other than 0x60 and 0x64 leave the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write mask |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data (status at 0x24, else zero) |
| src_raise | input | 2 | Engine cause pulses, one per source |
| msi_en | input | 1 | 1 selects message pulses, 0 selects the level line |
| irq_level | output | 1 | Level interrupt line |
| msi_req | output | 1 | One-cycle message request |

## Verification
Every write or engine pulse is captured at one rising edge, and the status, `irq_level` and `msi_req` all show its effect right after that same edge, so each result is due one cycle after its stimulus; `rd_data` then follows the status with no further delay. The bench drives stimulus on the falling edge, lets one rising edge pass, and samples all three results on the next falling edge, before any new stimulus. A message pulse is checked in exactly that cycle and checked absent one cycle later, through the following operation's sample.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
   // Default byte offsets of the register port
   localparam int unsigned STAT_OFS_DEF  = 32'h24;
   localparam int unsigned RAISE_OFS_DEF = 32'h60;
   localparam int unsigned LOWER_OFS_DEF = 32'h64;
   // Kind of write seen on the port
   typedef enum logic [1:0] {
      WK_NONE  = 2'd0,
      WK_RAISE = 2'd1,
      WK_LOWER = 2'd2
   } wr_kind_e;
endpackage

// File: rtl/irq_hub_decode.sv
module irq_hub_decode
   import irq_hub_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned RAISE_OFS = RAISE_OFS_DEF,
   parameter int unsigned LOWER_OFS = LOWER_OFS_DEF
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] sw_raise_mask,
   output logic [DATA_W-1:0] sw_lower_mask,
   output logic              sw_raise_op
);
   localparam logic [ADDR_W-1:0] RAISE_A = ADDR_W'(RAISE_OFS);
   localparam logic [ADDR_W-1:0] LOWER_A = ADDR_W'(LOWER_OFS);

   if (RAISE_OFS == LOWER_OFS) begin : g_bad_ofs
      $error("raise and lower offsets must differ");
   end

   wr_kind_e kind;

   always_comb begin
      kind = WK_NONE;
      if (wr_en) begin
         if (wr_addr == RAISE_A)      kind = WK_RAISE;
         else if (wr_addr == LOWER_A) kind = WK_LOWER;
      end
   end

   assign sw_raise_op   = (kind == WK_RAISE);
   assign sw_raise_mask = (kind == WK_RAISE) ? wr_data : '0;
   assign sw_lower_mask = (kind == WK_LOWER) ? wr_data : '0;
endmodule

// File: rtl/irq_hub_src_map.sv
module irq_hub_src_map #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned N_SRC  = 2,
   parameter logic [N_SRC*8-1:0] SRC_POS = 16'h0800
) (
   input  logic [N_SRC-1:0]  src_raise,
   output logic [DATA_W-1:0] hw_mask,
   output logic              hw_op
);
   logic [DATA_W-1:0] lane [N_SRC];

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      localparam int unsigned POS = int'(SRC_POS[g*8 +: 8]);
      if (POS >= DATA_W) begin : g_bad_pos
         $error("source bit position outside the status word");
      end
      localparam logic [DATA_W-1:0] BITV = DATA_W'(1) << POS;
      assign lane[g] = src_raise[g] ? BITV : '0;
   end

   always_comb begin
      hw_mask = '0;
      for (int i = 0; i < N_SRC; i++) hw_mask = hw_mask | lane[i];
   end

   assign hw_op = |src_raise;
endmodule

// File: rtl/irq_hub_store.sv
module irq_hub_store #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] raise_mask,
   input  logic [DATA_W-1:0] lower_mask,
   output logic [DATA_W-1:0] status_q,
   output logic [DATA_W-1:0] status_next
);
   // clearing goes first, setting second: a fresh cause survives
   assign status_next = (status_q & ~lower_mask) | raise_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= status_next;
   end
endmodule

// File: rtl/irq_hub_deliver.sv
module irq_hub_deliver #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msi_en,
   input  logic              raise_op,
   input  logic [DATA_W-1:0] status_next,
   output logic              irq_level,
   output logic              msi_req
);
   logic pending_next;
   assign pending_next = |status_next;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_level <= 1'b0;
         msi_req   <= 1'b0;
      end else begin
         irq_level <= ~msi_en & pending_next;
         msi_req   <= msi_en & raise_op & pending_next;
      end
   end
endmodule

// File: rtl/irq_cause_hub.sv
module irq_cause_hub
   import irq_hub_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned N_SRC     = 2,
   parameter logic [N_SRC*8-1:0] SRC_POS = 16'h0800,
   parameter int unsigned STAT_OFS  = STAT_OFS_DEF,
   parameter int unsigned RAISE_OFS = RAISE_OFS_DEF,
   parameter int unsigned LOWER_OFS = LOWER_OFS_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [N_SRC-1:0]  src_raise,
   input  logic              msi_en,
   output logic              irq_level,
   output logic              msi_req
);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

   if (STAT_OFS >= (1 << ADDR_W) || RAISE_OFS >= (1 << ADDR_W) ||
       LOWER_OFS >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register offset does not fit the address width");
   end
   if (N_SRC == 0) begin : g_bad_src
      $error("at least one engine source is needed");
   end

   logic [DATA_W-1:0] sw_raise_mask, sw_lower_mask, hw_mask;
   logic [DATA_W-1:0] status_q, status_next;
   logic              sw_raise_op, hw_op;

   irq_hub_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .RAISE_OFS(RAISE_OFS), .LOWER_OFS(LOWER_OFS)
   ) decode_i (
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sw_raise_mask(sw_raise_mask), .sw_lower_mask(sw_lower_mask),
      .sw_raise_op(sw_raise_op)
   );

   irq_hub_src_map #(
      .DATA_W(DATA_W), .N_SRC(N_SRC), .SRC_POS(SRC_POS)
   ) src_map_i (
      .src_raise(src_raise), .hw_mask(hw_mask), .hw_op(hw_op)
   );

   irq_hub_store #(.DATA_W(DATA_W)) store_i (
      .clk(clk), .rst_n(rst_n),
      .raise_mask(sw_raise_mask | hw_mask),
      .lower_mask(sw_lower_mask),
      .status_q(status_q), .status_next(status_next)
   );

   irq_hub_deliver #(.DATA_W(DATA_W)) deliver_i (
      .clk(clk), .rst_n(rst_n), .msi_en(msi_en),
      .raise_op(sw_raise_op | hw_op),
      .status_next(status_next),
      .irq_level(irq_level), .msi_req(msi_req)
   );

   assign rd_data = (rd_addr == STAT_A) ? status_q : '0;
endmodule

// File: rtl/irq_cause_hub_chk.sv
module irq_cause_hub_chk #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned N_SRC     = 2,
   parameter logic [N_SRC*8-1:0] SRC_POS = 16'h0800,
   parameter int unsigned RAISE_OFS = 32'h60,
   parameter int unsigned LOWER_OFS = 32'h64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [N_SRC-1:0]  src_raise,
   input logic              msi_en,
   input logic              irq_level,
   input logic              msi_req,
   input logic [DATA_W-1:0] status
);
   localparam logic [ADDR_W-1:0] RAISE_A = ADDR_W'(RAISE_OFS);
   localparam logic [ADDR_W-1:0] LOWER_A = ADDR_W'(LOWER_OFS);

   // R2
   raise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && wr_addr == RAISE_A) |-> ((status & $past(wr_data)) == $past(wr_data)));

   // R7
   level_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!msi_en) |-> (irq_level == (status != '0)));

   // R10
   level_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(msi_en) |-> !irq_level);

   // R9
   msi_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msi_req |-> ($past(msi_en) && status != '0));

   // R9
   lower_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && wr_addr == LOWER_A && src_raise == '0) |-> !msi_req);

   for (genvar g = 0; g < N_SRC; g++) begin : g_src_chk
      localparam int unsigned POS = int'(SRC_POS[g*8 +: 8]);
      // R5 R6
      src_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(src_raise[g]) |-> status[POS]);
   end
endmodule

bind irq_cause_hub irq_cause_hub_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SRC(N_SRC), .SRC_POS(SRC_POS),
   .RAISE_OFS(RAISE_OFS), .LOWER_OFS(LOWER_OFS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .src_raise(src_raise), .msi_en(msi_en),
   .irq_level(irq_level), .msi_req(msi_req), .status(status_q)
);

// File: tb/irq_cause_hub_tb.sv
`timescale 1ns/1ps
module irq_cause_hub_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = 8'h00;
   logic [31:0] wr_data = '0;
   logic [7:0]  rd_addr = 8'h24;
   logic [31:0] rd_data;
   logic [1:0]  src_raise = 2'b00;
   logic        msi_en = 1'b0;
   logic        irq_level, msi_req;

   int n_run = 0;
   int n_fail = 0;
   logic [31:0] m_stat = '0;

   always #2 clk = ~clk;

   irq_cause_hub dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .src_raise(src_raise), .msi_en(msi_en),
      .irq_level(irq_level), .msi_req(msi_req)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one operation: drive at falling edge, sample one edge later
   task automatic op(bit we, logic [7:0] a, logic [31:0] d, logic [1:0] s,
                     bit me, string tag);
      logic [31:0] rmask, lmask, nxt;
      bit rop;
      wr_en = we; wr_addr = a; wr_data = d; src_raise = s; msi_en = me;
      rop   = (we && a == 8'h60) || (s != 2'b00);
      rmask = ((we && a == 8'h60) ? d : 32'h0) |
              (s[0] ? 32'h1 : 32'h0) | (s[1] ? 32'h100 : 32'h0);
      lmask = (we && a == 8'h64) ? d : 32'h0;
      nxt   = (m_stat & ~lmask) | rmask;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; src_raise = 2'b00;
      m_stat = nxt;
      chk({tag, " status"}, rd_data, nxt);
      chk({tag, " level"}, {31'b0, irq_level}, {31'b0, !me && nxt != 0});
      chk({tag, " msi"}, {31'b0, msi_req}, {31'b0, me && rop && nxt != 0});
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 during reset
      chk("R1 rst status", rd_data, 32'h0);
      chk("R1 rst level", {31'b0, irq_level}, 32'h0);
      chk("R1 rst msi", {31'b0, msi_req}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle status", rd_data, 32'h0);
      chk("R1 idle level", {31'b0, irq_level}, 32'h0);

      // R2 R3 R7 R8: single-bit sweep in level mode
      for (int b = 0; b < 32; b++) begin
         op(1, 8'h60, 32'h1 << b, 2'b00, 0, "R2/R7 raise bit");
         op(1, 8'h64, 32'h1 << b, 2'b00, 0, "R3/R8 lower bit");
      end
      // R8: partial lowers keep the line high
      op(1, 8'h60, 32'h0000_00F0, 2'b00, 0, "R2 raise F0");
      op(1, 8'h60, 32'h0000_0F00, 2'b00, 0, "R2 raise F00");
      op(1, 8'h64, 32'h0000_00F0, 2'b00, 0, "R8 partial lower");
      op(1, 8'h64, 32'h0000_0300, 2'b00, 0, "R8 partial lower 2");
      op(1, 8'h64, 32'hFFFF_FFFF, 2'b00, 0, "R8 full lower");
      // R5 engine pulses
      for (int s = 1; s < 4; s++) begin
         op(0, 8'h00, 32'h0, 2'(s), 0, "R5 engine pulse");
         op(1, 8'h64, 32'hFFFF_FFFF, 2'b00, 0, "R3 clear after R5");
      end
      // R6 collisions
      op(0, 8'h00, 32'h0, 2'b01, 0, "R5 set bit0");
      op(1, 8'h64, 32'h0000_0101, 2'b01, 0, "R6 lower+engine bit0");
      op(1, 8'h64, 32'h0000_0101, 2'b10, 0, "R6 lower+engine bit8");
      op(1, 8'h60, 32'h0000_0010, 2'b11, 0, "R6 sw+engine raise");
      op(1, 8'h64, 32'hFFFF_FFFF, 2'b00, 0, "R3 clear all");
      // R11 other write offsets
      op(1, 8'h60, 32'h0000_8000, 2'b00, 0, "R2 set for R11");
      for (int a = 0; a < 256; a += 4) begin
         if (a != 8'h60 && a != 8'h64)
            op(1, 8'(a), 32'hFFFF_FFFF, 2'b00, 0, "R11 stray write");
      end
      // R4 read decode
      for (int a = 0; a < 256; a += 4) begin
         rd_addr = 8'(a);
         #1;
         chk("R4 read decode", rd_data, (a == 8'h24) ? m_stat : 32'h0);
      end
      rd_addr = 8'h24;
      op(1, 8'h64, 32'hFFFF_FFFF, 2'b00, 0, "R3 clear before msi");

      // R9 R10 message mode
      op(1, 8'h60, 32'h0, 2'b00, 1, "R9 raise zero, empty");
      for (int b = 0; b < 32; b++) begin
         op(1, 8'h60, 32'h1 << b, 2'b00, 1, "R9/R10 raise bit");
         op(0, 8'h00, 32'h0, 2'b00, 1, "R9 one-cycle pulse");
         op(1, 8'h64, 32'h1 << b, 2'b00, 1, "R9 lower silent");
      end
      op(0, 8'h00, 32'h0, 2'b10, 1, "R9 engine msi");
      op(0, 8'h00, 32'h0, 2'b10, 1, "R9 repeated engine msi");
      op(1, 8'h60, 32'h0, 2'b00, 1, "R9 raise zero, pending");
      op(1, 8'h64, 32'h0000_0001, 2'b00, 1, "R9 lower no-op silent");
      // R10 back to level mode: follows status
      op(0, 8'h00, 32'h0, 2'b00, 0, "R10 return high");
      op(0, 8'h00, 32'h0, 2'b00, 1, "R10 msi again");
      op(1, 8'h64, 32'hFFFF_FFFF, 2'b00, 1, "R10 clear in msi");
      op(0, 8'h00, 32'h0, 2'b00, 0, "R10 return low");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule